// File: doc/BRIEF.md
# Scanline Memory Refresh Scheduler

This block decides, once per scanline, when the system's dynamic memory is refreshed. The beam counter supplies the master-cycle position inside the current line, the line number, the frame parity and the interlace mode. From these the block raises a refresh-busy window of fixed length, which stalls the CPU bus, and a one-cycle pulse that marks the start of that window.

The window starts at one of two in-line positions, 534 or 538. The block uses the two positions in turn on successive lines, so the distance from one refresh to the next is 1360 or 1368 master cycles. Both values are multiples of 8, which matches the 8-cycle step of the refresh timer.

One non-interlaced line in every second frame is 4 cycles short. On that line the turn is skipped and the next line reuses the same start position, so the spacing stays a multiple of 8. Because of this skip, the start position of line 0 inverts every two frames in non-interlaced mode. In interlaced mode the extra line in every second frame gives line 0 the sequence early, late, late, early over four frames.

Top module: `rfsh_sched`

## Requirements
- R1: After reset both outputs are low, and the first refresh window starts at in-line cycle 538.
- R2: `rfsh_start` is high for exactly one cycle per window: the cycle in which `line_cyc` equals the currently selected start value (534 or 538).
- R3: `rfsh_active` goes high in the same cycle as `rfsh_start` and stays high for exactly 40 consecutive cycles.
- R4: On ordinary scanlines the start value alternates between 534 and 538 from one line to the next.
- R5: When `interlace`=0, `field_odd`=1 and `line_num`=240, the alternation does not advance, so line 241 uses the same start value as line 240.
- R6: When `interlace`=1, line 240 of an odd field advances the alternation like any other line.
- R7: In non-interlaced operation (262 lines per frame, line 240 of odd frames 1360 cycles long), line 0 has the same start value in frames F and F+1 and the opposite value in frame F+2.
- R8: In interlaced operation (263 lines in even fields, 262 in odd fields), line 0 of four successive fields starting with an even field follows the pattern A, B, B, A with A different from B.
- R9: The distance between two consecutive refresh starts is always 1360 or 1368 master cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; one edge for each master cycle |
| rst | input | 1 | Synchronous reset, active high |
| line_cyc | input | 11 | Master-cycle position within the current scanline |
| line_num | input | 9 | Current scanline number |
| field_odd | input | 1 | High during odd frames or fields |
| interlace | input | 1 | High when interlaced scanning is selected |
| rfsh_active | output | 1 | Refresh window in progress; the CPU bus is stalled |
| rfsh_start | output | 1 | One-cycle pulse on the first cycle of a refresh window |

## Verification
The bench first runs short sequences of ordinary lines. These show that the alternation happens and that each window has the right start cycle and the right length. It then runs four complete non-interlaced frames, which include the short line. Comparing the start on line 240 with the start on line 241 shows whether the skip is applied. The spacing check at the frame boundary shows whether the two-frame inversion is a result of that skip.

Four interlaced fields with the extra line are then run. They separate correct mode qualification of the skip from a skip that ignores the mode: line 240 of the odd field must still advance, and line 0 must follow the A, B, B, A order.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
    localparam int CYC_W      = 11;
    localparam int LINE_W     = 9;
    localparam int POS_EARLY  = 534;
    localparam int POS_LATE   = 538;
    localparam int RFSH_LEN   = 40;
    localparam int SHORT_LINE = 240;
    localparam int LEFT_W     = $clog2(RFSH_LEN + 1);

    typedef enum logic { SEL_EARLY = 1'b0, SEL_LATE = 1'b1 } pos_sel_e;

    typedef struct packed {
        logic              busy;
        logic [LEFT_W-1:0] left;
    } win_state_t;

    function automatic logic [CYC_W-1:0] start_pos(pos_sel_e sel);
        return (sel == SEL_LATE) ? CYC_W'(POS_LATE) : CYC_W'(POS_EARLY);
    endfunction
endpackage

// File: rtl/rfsh_phase.sv
module rfsh_phase
    import rfsh_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_evt,
    input  logic     hold_line,
    output pos_sel_e sel
);
    pos_sel_e sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= SEL_LATE;
        end else if (start_evt && !hold_line) begin
            sel_q <= (sel_q == SEL_LATE) ? SEL_EARLY : SEL_LATE;
        end
    end

    assign sel = sel_q;
endmodule

// File: rtl/rfsh_window.sv
module rfsh_window
    import rfsh_pkg::*;
#(
    parameter int LEN = RFSH_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    output logic win_start,
    output logic win_active
);
    localparam int LW = $clog2(LEN + 1);

    logic [LW-1:0] left_q;
    logic          idle;

    assign idle       = (left_q == '0);
    assign win_start  = hit && idle;
    assign win_active = win_start || !idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (win_start) begin
            left_q <= LW'(LEN - 1);
        end else if (!idle) begin
            left_q <= left_q - LW'(1);
        end
    end
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int CW    = CYC_W,
    parameter int LNW   = LINE_W,
    parameter int SHORT = SHORT_LINE,
    parameter int LEN   = RFSH_LEN
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [CW-1:0]  line_cyc,
    input  logic [LNW-1:0] line_num,
    input  logic           field_odd,
    input  logic           interlace,
    output logic           rfsh_active,
    output logic           rfsh_start
);
    pos_sel_e      sel;
    logic [CW-1:0] start_val;
    logic          hit;
    logic          hold_line;

    assign start_val = CW'(start_pos(sel));
    assign hit       = (line_cyc == start_val);
    assign hold_line = !interlace && field_odd && (line_num == LNW'(SHORT));

    rfsh_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .start_evt (rfsh_start),
        .hold_line (hold_line),
        .sel       (sel)
    );

    rfsh_window #(.LEN(LEN)) u_window (
        .clk        (clk),
        .rst        (rst),
        .hit        (hit),
        .win_start  (rfsh_start),
        .win_active (rfsh_active)
    );
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
    parameter int CW  = 11,
    parameter int LEN = 40
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] line_cyc,
    input logic          rfsh_active,
    input logic          rfsh_start
);
    localparam int RW = $clog2(LEN + 2);
    logic [RW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)              run_cnt <= '0;
        else if (rfsh_active) run_cnt <= run_cnt + RW'(1);
        else                  run_cnt <= '0;
    end

    AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rfsh_start |=> !rfsh_start);                                  // R2
    AST_START_POS: assert property (@(posedge clk) disable iff (rst)
        rfsh_start |-> (line_cyc == CW'(534) || line_cyc == CW'(538))); // R4
    AST_RISE_WITH_START: assert property (@(posedge clk) disable iff (rst)
        $rose(rfsh_active) |-> rfsh_start);                           // R3
    AST_START_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        rfsh_start |-> rfsh_active);                                  // R3
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        rfsh_active |-> (run_cnt < RW'(LEN)));                        // R3
    AST_FULL_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $fell(rfsh_active) |-> (run_cnt == RW'(LEN)));                // R3
endmodule

bind rfsh_sched rfsh_sched_chk #(.CW(CW), .LEN(LEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .line_cyc    (line_cyc),
    .rfsh_active (rfsh_active),
    .rfsh_start  (rfsh_start)
);

// File: tb/rfsh_sched_tb_top.sv
module rfsh_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [10:0] line_cyc;
    logic [8:0]  line_num;
    logic        field_odd;
    logic        interlace;
    logic        rfsh_active;
    logic        rfsh_start;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    int exp_late;
    int prev_start, prev_len;
    bit have_prev;
    int got_start;
    int frame_l0[4];
    int s240, s241;

    always #5 clk = ~clk;

    rfsh_sched dut_i (
        .clk(clk), .rst(rst), .line_cyc(line_cyc), .line_num(line_num),
        .field_odd(field_odd), .interlace(interlace),
        .rfsh_active(rfsh_active), .rfsh_start(rfsh_start)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp=<190000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, expv);
        end
    endtask

    task automatic step(input int c);
        @(negedge clk);
        line_cyc = 11'(c);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; line_cyc = 0; line_num = 0; field_odd = 0; interlace = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(rfsh_active == 0 && rfsh_start == 0, "R1 outputs low in reset",
            {rfsh_active, rfsh_start}, 0);
        @(negedge clk);
        rst = 0;
        #1;
        chk(rfsh_active == 0 && rfsh_start == 0, "R1 outputs low after reset",
            {rfsh_active, rfsh_start}, 0);
        exp_late = 1; have_prev = 0;
    endtask

    // One scanline: sweep the window region and check pulse, length, spacing
    task automatic run_line(input int ln, input int len, input bit il, input bit odd);
        int pulses = 0, act_cnt = 0, first = -1, expst;
        line_num = 9'(ln); field_odd = odd; interlace = il;
        expst = exp_late ? 538 : 534;
        step(0);
        if (rfsh_active) act_cnt++;
        for (int c = 530; c < 582; c++) begin
            step(c);
            if (rfsh_start) begin pulses++; if (first < 0) first = c; end
            if (rfsh_active) act_cnt++;
        end
        step(len - 1);
        if (rfsh_active) act_cnt++;
        chk(pulses == 1, "R2 one pulse per line", pulses, 1);
        chk(first == expst, "R4 start position", first, expst);
        chk(act_cnt == 40, "R3 window length", act_cnt, 40);
        if (have_prev)
            chk((prev_len - prev_start + first == 1360) || (prev_len - prev_start + first == 1368),
                "R9 refresh spacing", prev_len - prev_start + first, 1364);
        have_prev = 1; prev_start = first; prev_len = len;
        got_start = first;
        if (!(!il && odd && ln == 240)) exp_late = !exp_late;
    endtask

    task automatic run_frame(input int idx, input bit il, input bit odd);
        int nl = (il && !odd) ? 263 : 262;
        for (int ln = 0; ln < nl; ln++) begin
            run_line(ln, (!il && odd && ln == 240) ? 1360 : 1364, il, odd);
            if (ln == 0)   frame_l0[idx] = got_start;
            if (ln == 240) s240 = got_start;
            if (ln == 241) s241 = got_start;
        end
    endtask

    task automatic t_reset_first();
        do_reset();
        run_line(5, 1364, 0, 0);
        chk(got_start == 538, "R1 first refresh at 538", got_start, 538);
    endtask

    task automatic t_alternate();
        int a, b, c;
        run_line(6, 1364, 0, 0); a = got_start;
        run_line(7, 1364, 0, 0); b = got_start;
        run_line(8, 1364, 0, 0); c = got_start;
        chk(a != b, "R4 alternation a/b", b, (a == 534) ? 538 : 534);
        chk(a == c, "R4 alternation a/c", c, a);
    endtask

    task automatic t_noninterlace_frames();
        int h240[2], h241[2];
        do_reset();
        for (int f = 0; f < 4; f++) begin
            run_frame(f, 0, f[0]);
            if (f < 2) begin h240[f] = s240; h241[f] = s241; end
        end
        chk(h240[1] == h241[1], "R5 odd frame line 241 repeats 240", h241[1], h240[1]);
        chk(h240[0] != h241[0], "R4 even frame line 240/241 alternate", h241[0],
            (h240[0] == 534) ? 538 : 534);
        chk(frame_l0[0] == frame_l0[1], "R7 frames 0/1 same", frame_l0[1], frame_l0[0]);
        chk(frame_l0[2] != frame_l0[0], "R7 frame 2 inverted", frame_l0[2],
            (frame_l0[0] == 534) ? 538 : 534);
        chk(frame_l0[3] == frame_l0[2], "R7 frames 2/3 same", frame_l0[3], frame_l0[2]);
    endtask

    task automatic t_interlace_frames();
        int o240 = 0, o241 = 0;
        do_reset();
        for (int f = 0; f < 4; f++) begin
            run_frame(f, 1, f[0]);
            if (f == 1) begin o240 = s240; o241 = s241; end
        end
        chk(o240 != o241, "R6 interlace odd line 240 advances", o241,
            (o240 == 534) ? 538 : 534);
        chk(frame_l0[0] != frame_l0[1], "R8 fields 0/1 differ", frame_l0[1],
            (frame_l0[0] == 534) ? 538 : 534);
        chk(frame_l0[1] == frame_l0[2], "R8 fields 1/2 same", frame_l0[2], frame_l0[1]);
        chk(frame_l0[3] == frame_l0[0], "R8 field 3 back to A", frame_l0[3], frame_l0[0]);
    endtask

    initial begin
        rst = 1; line_cyc = 0; line_num = 0; field_odd = 0; interlace = 0;
        t_reset_first();
        t_alternate();
        t_noninterlace_frames();
        t_interlace_frames();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule